// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block conditions a small group of external interrupt pins, four or six of them, and turns each one into a clean request line. Every pin first passes through a synchroniser. It is then judged by its own trigger rule, which is one of: active-high level, active-low level, rising edge, falling edge, or either edge. Edge events are held in a sticky pending bit until software acknowledges them. Level requests follow the synchronised pin and are never latched. A per-pin enable gates the final request. The consumer decides whether the request lines go straight to processor interrupt inputs or are folded into a wider status vector.

Configuration is held in 32-bit words on a plain register bus with write strobe, word address and combinational read data. Each word carries the fields of four pins. A pin uses word `p / 4`, and its position inside every field of that word is `p % 4`. The second word exists only when more than four pins are built. The register bus and the pin inputs are control signals, so they have no valid/ready handshake. A write is taken on every clock edge where the strobe is high, and it cannot be stalled.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every request output is 0. Every pin is configured as active-low level with its enable off. Word 0 reads 0x0000F000, and word 1 reads 0x00003000 when six pins are built.
- R2: With level=1 and sense=1, a pin's request equals its enable ANDed with the synchronised pin value. A pin change at the inputs shows on the request after two clock edges.
- R3: With level=1 and sense=0, a pin's request equals its enable ANDed with the inverted synchronised pin value.
- R4: With level=0, both=0 and sense=1, a rising edge of the synchronised pin sets a sticky pending bit. The request rises after the third clock edge following the pin change and stays high after the pin returns low. A falling edge sets nothing.
- R5: With level=0, both=0 and sense=0, only a falling edge sets the pending bit. A rising edge sets nothing.
- R6: With level=0 and both=1, either edge sets the pending bit, whatever the sense bit holds. With level=1, the both bit has no effect and the pin behaves as a level pin.
- R7: The enable bit gates the request: with enable 0 the request is 0. An edge that arrives while the pin is disabled is still latched, and it shows as soon as the enable is set.
- R8: Writing 1 to a pin's clear bit drops its pending bit at that write's clock edge. Writing 0 leaves the pending bit alone. Clear bits always read back as 0.
- R9: When a clear write and a newly detected edge meet on the same clock edge, the edge wins and the pending bit stays set.
- R10: Field layout in each word: bits 3:0 clear, 7:4 sense, 11:8 both, 15:12 level, 19:16 enable. Bit `p % 4` of each field belongs to pin p. Pins 0 to 3 live in word 0 (`cfg_addr`=0) and pins 4 to 5 in word 1 (`cfg_addr`=1).
- R11: Bits 31:20 and the field bits of pins that are not built read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Configuration word index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed word, combinational |
| irq_req | output | NUM_PINS | Conditioned request per pin |

## Verification
The pins are driven with slow level changes, isolated single edges of each polarity, and return-to-idle transitions after an edge. Together these separate latched edge behaviour from followed level behaviour, and separate a rising-edge rule from a falling-edge rule. Edges are also raised while a pin is disabled, and a clear write is timed onto the exact edge where a new edge is detected. These cases separate gating from latching and show which side wins the clear-versus-edge race. All-ones writes to both words expose the field layout and the bits that must read as zero.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int REG_W        = 32;
  localparam int PINS_PER_REG = 4;

  // field base positions inside a configuration word
  localparam int CLR_LSB   = 0;
  localparam int SENSE_LSB = 4;
  localparam int BOTH_LSB  = 8;
  localparam int LEVEL_LSB = 12;
  localparam int EN_LSB    = 16;

  typedef struct packed {
    logic level;
    logic sense;
    logic both;
    logic en;
  } pin_cfg_t;

  typedef enum logic [2:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  // level decides the class first; both-edge only matters in edge class
  function automatic trig_e trig_decode(pin_cfg_t c);
    if (c.level)
      return c.sense ? TRIG_HIGH : TRIG_LOW;
    else if (c.both)
      return TRIG_BOTH;
    else
      return c.sense ? TRIG_RISE : TRIG_FALL;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_now,
  output logic [W-1:0] q_prev
);

  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] chain [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
    end
  end

  // last synchroniser stage and one extra history stage for edge finding
  assign q_now  = chain[STAGES-1];
  assign q_prev = chain[STAGES];

endmodule

// File: rtl/ext_irq_cfg_regs.sv
module ext_irq_cfg_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int ADDR_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output pin_cfg_t          cfg_out [NUM_PINS],
  output logic [NUM_PINS-1:0] clr_pulse
);

  pin_cfg_t cfg_q [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WORD = p / PINS_PER_REG;
    localparam int FLD  = p % PINS_PER_REG;

    logic hit;
    assign hit = cfg_wr && (cfg_addr == ADDR_W'(WORD));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        // default trigger: active-low level, disabled
        cfg_q[p] <= '{level: 1'b1, sense: 1'b0, both: 1'b0, en: 1'b0};
      end else if (hit) begin
        cfg_q[p].sense <= cfg_wdata[SENSE_LSB + FLD];
        cfg_q[p].both  <= cfg_wdata[BOTH_LSB  + FLD];
        cfg_q[p].level <= cfg_wdata[LEVEL_LSB + FLD];
        cfg_q[p].en    <= cfg_wdata[EN_LSB    + FLD];
      end
    end

    assign clr_pulse[p] = hit && cfg_wdata[CLR_LSB + FLD];
    assign cfg_out[p]   = cfg_q[p];
  end

  always_comb begin
    cfg_rdata = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (cfg_addr == ADDR_W'(p / PINS_PER_REG)) begin
        cfg_rdata[SENSE_LSB + (p % PINS_PER_REG)] = cfg_q[p].sense;
        cfg_rdata[BOTH_LSB  + (p % PINS_PER_REG)] = cfg_q[p].both;
        cfg_rdata[LEVEL_LSB + (p % PINS_PER_REG)] = cfg_q[p].level;
        cfg_rdata[EN_LSB    + (p % PINS_PER_REG)] = cfg_q[p].en;
      end
    end
  end

endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] smp_now,
  input  logic [NUM_PINS-1:0] smp_prev,
  input  pin_cfg_t            cfg_in [NUM_PINS],
  input  logic [NUM_PINS-1:0] clr_pulse,
  output logic [NUM_PINS-1:0] edge_hit,
  output logic [NUM_PINS-1:0] pend_q,
  output logic [NUM_PINS-1:0] irq_req
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    trig_e mode;
    logic  level_hit;

    assign mode = trig_decode(cfg_in[p]);

    always_comb begin
      unique case (mode)
        TRIG_BOTH: edge_hit[p] = smp_now[p] ^ smp_prev[p];
        TRIG_RISE: edge_hit[p] = smp_now[p] & ~smp_prev[p];
        TRIG_FALL: edge_hit[p] = ~smp_now[p] & smp_prev[p];
        default:   edge_hit[p] = 1'b0;
      endcase
    end

    assign level_hit = ((mode == TRIG_HIGH) &  smp_now[p]) |
                       ((mode == TRIG_LOW)  & ~smp_now[p]);

    // a fresh edge outranks a clear arriving on the same edge
    always_ff @(posedge clk) begin
      if (!rst_n)            pend_q[p] <= 1'b0;
      else if (edge_hit[p])  pend_q[p] <= 1'b1;
      else if (clr_pulse[p]) pend_q[p] <= 1'b0;
    end

    assign irq_req[p] = cfg_in[p].en &
                        (level_hit | (pend_q[p] & ~cfg_in[p].level));
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic [NUM_PINS-1:0] irq_req
);

  logic [NUM_PINS-1:0] smp_now;
  logic [NUM_PINS-1:0] smp_prev;
  logic [NUM_PINS-1:0] clr_pulse;
  logic [NUM_PINS-1:0] edge_hit;
  logic [NUM_PINS-1:0] pend_q;
  logic [NUM_PINS-1:0] en_vec;
  logic [NUM_PINS-1:0] lvl_vec;
  pin_cfg_t            pin_cfg [NUM_PINS];

  ext_irq_sync #(
    .W      (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (pin_in),
    .q_now  (smp_now),
    .q_prev (smp_prev)
  );

  ext_irq_cfg_regs #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_out   (pin_cfg),
    .clr_pulse (clr_pulse)
  );

  ext_irq_trigger #(
    .NUM_PINS (NUM_PINS)
  ) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_now   (smp_now),
    .smp_prev  (smp_prev),
    .cfg_in    (pin_cfg),
    .clr_pulse (clr_pulse),
    .edge_hit  (edge_hit),
    .pend_q    (pend_q),
    .irq_req   (irq_req)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_vec
    assign en_vec[p]  = pin_cfg[p].en;
    assign lvl_vec[p] = pin_cfg[p].level;
  end

endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int NUM_PINS = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] irq_req,
  input logic [31:0]         cfg_rdata,
  input logic [NUM_PINS-1:0] en_vec,
  input logic [NUM_PINS-1:0] lvl_vec,
  input logic [NUM_PINS-1:0] edge_vec,
  input logic [NUM_PINS-1:0] clr_vec,
  input logic [NUM_PINS-1:0] pend_vec
);

  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~en_vec) == '0);

  // R11
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:20] == 12'h000);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    // R4
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_vec[p] |=> pend_vec[p]);

    // R8
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[p] && !edge_vec[p]) |=> !pend_vec[p]);

    // R9
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[p] && edge_vec[p]) |=> pend_vec[p]);

    // R6
    level_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_vec[p] |-> !edge_vec[p]);
  end

endmodule

bind ext_irq_ctrl ext_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .cfg_rdata (cfg_rdata),
  .en_vec    (en_vec),
  .lvl_vec   (lvl_vec),
  .edge_vec  (edge_hit),
  .clr_vec   (clr_pulse),
  .pend_vec  (pend_q)
);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;

  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic          cfg_wr = 1'b0;
  logic [0:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [NP-1:0] irq_req;

  int    n_checks = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  ext_irq_ctrl #(.NUM_PINS(NP)) uut (
    .clk (clk), .rst_n (rst_n), .pin_in (pin_in),
    .cfg_wr (cfg_wr), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata), .irq_req (irq_req)
  );

  // behavioural reference
  bit m_s1 [NP], m_s2 [NP], m_pv [NP], m_pend [NP];
  bit m_lvl [NP], m_sense [NP], m_both [NP], m_en [NP];

  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (!rst_n) begin
        m_s1[p] = 0; m_s2[p] = 0; m_pv[p] = 0; m_pend[p] = 0;
        m_lvl[p] = 1; m_sense[p] = 0; m_both[p] = 0; m_en[p] = 0;
      end else begin
        bit e;
        bit sel;
        e = 0;
        sel = cfg_wr && (cfg_addr == (p / 4));
        if (!m_lvl[p]) begin
          if (m_both[p])       e = (m_s2[p] != m_pv[p]);
          else if (m_sense[p]) e = m_s2[p] && !m_pv[p];
          else                 e = !m_s2[p] && m_pv[p];
        end
        if (e) m_pend[p] = 1;
        else if (sel && cfg_wdata[p % 4]) m_pend[p] = 0;
        if (sel) begin
          m_sense[p] = cfg_wdata[4 + p % 4];
          m_both[p]  = cfg_wdata[8 + p % 4];
          m_lvl[p]   = cfg_wdata[12 + p % 4];
          m_en[p]    = cfg_wdata[16 + p % 4];
        end
        m_pv[p] = m_s2[p];
        m_s2[p] = m_s1[p];
        m_s1[p] = pin_in[p];
      end
    end
  end

  function automatic logic [NP-1:0] mdl_req();
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++)
      r[p] = m_en[p] && (m_lvl[p] ? (m_s2[p] == m_sense[p]) : m_pend[p]);
    return r;
  endfunction

  function automatic logic [31:0] mdl_rd(logic a);
    logic [31:0] r;
    r = '0;
    for (int p = 0; p < NP; p++) begin
      if (a == (p / 4)) begin
        r[4 + p % 4]  = m_sense[p];
        r[8 + p % 4]  = m_both[p];
        r[12 + p % 4] = m_lvl[p];
        r[16 + p % 4] = m_en[p];
      end
    end
    return r;
  endfunction

  // per-cycle comparison against the reference, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      n_checks++;
      if (irq_req !== mdl_req()) begin
        n_fail++;
        $display("FAIL %s model irq_req: actual %b expected %b", cur_tag, irq_req, mdl_req());
      end
      n_checks++;
      if (cfg_rdata !== mdl_rd(cfg_addr[0])) begin
        n_fail++;
        $display("FAIL %s model cfg_rdata: actual %h expected %h", cur_tag, cfg_rdata, mdl_rd(cfg_addr[0]));
      end
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_up();
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // drives at the current negedge, returns at the next one
  task automatic wr(logic a, logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic chk_req(string tag, int p, logic exp);
    #1;
    n_checks++;
    if (irq_req[p] !== exp) begin
      n_fail++;
      $display("FAIL %s irq_req[%0d]: actual %b expected %b", tag, p, irq_req[p], exp);
    end
  endtask

  task automatic chk_rd(string tag, logic [31:0] exp);
    #1;
    n_checks++;
    if (cfg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s cfg_rdata: actual %h expected %h", tag, cfg_rdata, exp);
    end
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    cur_tag = "R1";
    chk_rd("R1", 32'h0000F000);
    n_checks++;
    if (irq_req !== '0) begin
      n_fail++;
      $display("FAIL R1 irq_req: actual %b expected 0", irq_req);
    end
    cfg_addr = 1'b1;
    chk_rd("R1", 32'h00003000);
    wait_cyc(1);

    // R3 active-low level on pin 0
    cur_tag = "R3";
    wr(1'b0, 32'h0001F000);
    chk_req("R3", 0, 1'b1);
    pin_in[0] = 1'b1; wait_cyc(3);
    chk_req("R3", 0, 1'b0);

    // R2 active-high level on pin 1
    cur_tag = "R2";
    wr(1'b0, 32'h0002F020);
    pin_in[1] = 1'b1; wait_cyc(3);
    chk_req("R2", 1, 1'b1);
    cur_tag = "R7";
    pin_in[0] = 1'b0; wait_cyc(3);
    chk_req("R7", 0, 1'b0);
    cur_tag = "R2";
    pin_in[1] = 1'b0; wait_cyc(3);
    chk_req("R2", 1, 1'b0);

    // R4 rising edge on pin 2, sticky
    cur_tag = "R4";
    wr(1'b0, 32'h0004B040);
    pin_in[2] = 1'b1; wait_cyc(3);
    chk_req("R4", 2, 1'b1);
    pin_in[2] = 1'b0; wait_cyc(3);
    chk_req("R4", 2, 1'b1);

    // R8 clear, zero-write has no effect, clear reads 0
    cur_tag = "R8";
    wr(1'b0, 32'h0004B040);
    chk_req("R8", 2, 1'b1);
    wr(1'b0, 32'h0004B044);
    chk_req("R8", 2, 1'b0);
    chk_rd("R8", 32'h0004B040);

    // R7 latch while disabled
    cur_tag = "R7";
    wr(1'b0, 32'h0000B040);
    pin_in[2] = 1'b1; wait_cyc(3);
    chk_req("R7", 2, 1'b0);
    wr(1'b0, 32'h0004B040);
    chk_req("R7", 2, 1'b1);
    wr(1'b0, 32'h0004B044);
    cur_tag = "R4";
    pin_in[2] = 1'b0; wait_cyc(3);
    chk_req("R4", 2, 1'b0);

    // R9 clear meeting a fresh edge
    cur_tag = "R9";
    pin_in[2] = 1'b1;
    wait_cyc(2);
    wr(1'b0, 32'h0004B044);
    chk_req("R9", 2, 1'b1);
    wr(1'b0, 32'h0004B044);
    chk_req("R9", 2, 1'b0);

    // R5 falling edge on pin 3
    cur_tag = "R5";
    wr(1'b0, 32'h00087000);
    pin_in[3] = 1'b1; wait_cyc(3);
    chk_req("R5", 3, 1'b0);
    pin_in[3] = 1'b0; wait_cyc(3);
    chk_req("R5", 3, 1'b1);
    wr(1'b0, 32'h00087008);
    chk_req("R5", 3, 1'b0);

    // R6 both edges on pin 4 (word 1, field 0), R10
    cur_tag = "R6";
    wr(1'b1, 32'h00012100);
    pin_in[4] = 1'b1; wait_cyc(3);
    chk_req("R6", 4, 1'b1);
    cur_tag = "R10";
    wr(1'b1, 32'h00012101);
    chk_req("R10", 4, 1'b0);
    cur_tag = "R6";
    pin_in[4] = 1'b0; wait_cyc(3);
    chk_req("R6", 4, 1'b1);
    wr(1'b1, 32'h00012101);
    chk_req("R6", 4, 1'b0);

    // R6 both bit ignored in level class (pin 5)
    wr(1'b1, 32'h00032320);
    pin_in[5] = 1'b1; wait_cyc(3);
    chk_req("R6", 5, 1'b1);
    pin_in[5] = 1'b0; wait_cyc(3);
    chk_req("R6", 5, 1'b0);

    // R10 / R11 layout and zero bits
    cur_tag = "R11";
    wr(1'b0, 32'hFFFFFFFF);
    chk_rd("R11", 32'h000FFFF0);
    chk_req("R2", 2, 1'b1);
    chk_req("R2", 3, 1'b0);
    wr(1'b1, 32'hFFFFFFFF);
    chk_rd("R10", 32'h00033330);

    wait_cyc(4);
    finish_up();
  end

endmodule